// File: doc/BRIEF.md
# Serial Panel Register Write Engine

This block carries out a single register write to a display controller over a three-wire serial link: an active-low select line, a serial clock and a serial data line. A write is started by a one-cycle request that carries an 8-bit register index and an 8-bit value. The engine sends two 16-bit words, each framed by its own low period on the select line. The first word is a fixed index prefix followed by the register index. The second word is a fixed value prefix followed by the value. Bits go out most significant first.

The receiver samples data on the rising serial clock edge. Each bit holds the clock low for one half-period and then high for one half-period. The half-period is a parameter counted in system clock cycles. Before each word, all three lines sit high for one half-period, and then select drops. After the second word, select goes high and clock and data go low.

While a write is in progress the engine holds busy high. It pulses done for one cycle once the lines have come back to rest. A request that arrives while busy is high is dropped. A request in the done cycle is accepted, so writes can run back to back.

Top module: `pnl_reg_writer`

## Requirements
- R1: After synchronous active-high reset, and whenever busy is low, select is high, clock is low, data is low, and done is low outside its pulse.
- R2: The first word framed by select low is 16 bits, captured on the rising clock edges MSB first, equal to {8'h70, index}. Exactly two words are sent per write.
- R3: The second word framed by select low is 16 bits, MSB first, equal to {8'h72, value}.
- R4: Before the first word, select, clock and data are all high for exactly HALF_CYC cycles, and then select falls.
- R5: Inside a word, every clock-low phase and every clock-high phase that ends while select is low lasts exactly HALF_CYC cycles. Data changes only together with a clock fall.
- R6: Between the two words, select rises and all three lines are high for exactly HALF_CYC cycles before select falls again.
- R7: After the second word, select is high and clock and data are low, and they are still so while done is high.
- R8: Busy is high from the cycle after an accepted request until done. Select is never low while busy is low.
- R9: A request that arrives while busy is high is ignored. The words sent are those of the request that was accepted.
- R10: Done is high for exactly one cycle. It rises one cycle after the lines first reach the resting state, and busy falls in the same cycle.
- R11: A request presented in the cycle in which done is high is accepted, and busy is high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle write request |
| idx_i | input | DW | Register index, sampled with an accepted request |
| val_i | input | DW | Value to write, sampled with an accepted request |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cs_o | output | 1 | Serial select, active low |
| sclk_o | output | 1 | Serial clock, receiver samples on rising edge |
| sdo_o | output | 1 | Serial data, MSB first |

## Verification
The completion pulse of one write and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising a new request on the very sample where it observes done. It then checks two things: busy must be high on the following sample, and the next pair of words must carry the new index and value. Done must also be low again on that following sample, which shows the pulse stayed one cycle long while a new write was already starting.

// File: rtl/pnl_wr_pkg.sv
package pnl_wr_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_RUN    = 2'd1,
    SQ_TAIL   = 2'd2,
    SQ_SETTLE = 2'd3
  } sq_state_e;

  typedef struct packed {
    logic cs;
    logic ck;
    logic dat;
  } pin_set_t;

  localparam pin_set_t PINS_REST = '{cs: 1'b1, ck: 1'b0, dat: 1'b0};
  localparam pin_set_t PINS_HIGH = '{cs: 1'b1, ck: 1'b1, dat: 1'b1};

endpackage

// File: rtl/pnl_half_timer.sv
module pnl_half_timer #(
  parameter int HALF_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int HALF_EFF = (HALF_CYC < 1) ? 1 : HALF_CYC;
  localparam int HC_W = (HALF_EFF > 1) ? $clog2(HALF_EFF) : 1;
  localparam logic [HC_W-1:0] HC_END = HC_W'(HALF_EFF - 1);

  logic [HC_W-1:0] hc_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      hc_q <= '0;
    end else if (hc_q == HC_END) begin
      hc_q <= '0;
    end else begin
      hc_q <= hc_q + HC_W'(1);
    end
  end

  assign tick_o = run_i && (hc_q == HC_END);

endmodule

// File: rtl/pnl_phase_seq.sv
module pnl_phase_seq
  import pnl_wr_pkg::*;
#(
  parameter int PH_LAST = 65,
  parameter int PH_W    = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            tick_i,
  output sq_state_e       st_o,
  output logic [PH_W-1:0] ph_o,
  output logic            load_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam logic [PH_W-1:0] PH_END = PH_W'(PH_LAST);

  sq_state_e       st_q;
  logic [PH_W-1:0] ph_q;
  logic            busy_q;
  logic            done_q;

  assign load_o = start_i && (st_q == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      ph_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (start_i) begin
            st_q   <= SQ_RUN;
            ph_q   <= '0;
            busy_q <= 1'b1;
          end
        end
        SQ_RUN: begin
          if (tick_i) begin
            if (ph_q == PH_END) begin
              st_q <= SQ_TAIL;
              ph_q <= '0;
            end else begin
              ph_q <= ph_q + PH_W'(1);
            end
          end
        end
        SQ_TAIL: st_q <= SQ_SETTLE;
        SQ_SETTLE: begin
          st_q   <= SQ_IDLE;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign st_o   = st_q;
  assign ph_o   = ph_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R10

endmodule

// File: rtl/pnl_pin_decode.sv
module pnl_pin_decode
  import pnl_wr_pkg::*;
#(
  parameter int              DW      = 8,
  parameter logic [DW-1:0]   IDX_PFX = 8'h70,
  parameter logic [DW-1:0]   DAT_PFX = 8'h72,
  parameter int              PH_W    = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [DW-1:0]   idx_i,
  input  logic [DW-1:0]   val_i,
  input  logic            busy_i,
  input  sq_state_e       st_i,
  input  logic [PH_W-1:0] ph_i,
  output logic            cs_o,
  output logic            ck_o,
  output logic            dat_o
);
  localparam int FW  = 2 * DW;
  localparam int PPF = 2 * FW;
  localparam logic [PH_W-1:0] PH_PRE = '0;
  localparam logic [PH_W-1:0] PH_GAP = PH_W'(PPF + 1);

  logic [FW-1:0]   idx_fr_q;
  logic [FW-1:0]   dat_fr_q;
  logic [FW-1:0]   fr_sel;
  logic [FW-1:0]   fr_shift;
  logic [PH_W-1:0] k;
  pin_set_t        nxt;
  pin_set_t        pins_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_fr_q <= '0;
      dat_fr_q <= '0;
    end else if (load_i) begin
      idx_fr_q <= {IDX_PFX, idx_i};
      dat_fr_q <= {DAT_PFX, val_i};
    end
  end

  always_comb begin
    nxt      = PINS_REST;
    k        = '0;
    fr_sel   = idx_fr_q;
    fr_shift = '0;
    if (st_i == SQ_RUN) begin
      if (ph_i == PH_PRE || ph_i == PH_GAP) begin
        nxt = PINS_HIGH;
      end else begin
        if (ph_i < PH_GAP) begin
          k      = ph_i - PH_W'(1);
          fr_sel = idx_fr_q;
        end else begin
          k      = ph_i - PH_GAP - PH_W'(1);
          fr_sel = dat_fr_q;
        end
        fr_shift = fr_sel << (k >> 1);
        nxt.cs   = 1'b0;
        nxt.ck   = k[0];
        nxt.dat  = fr_shift[FW-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pins_q <= PINS_REST;
    else     pins_q <= nxt;
  end

  assign cs_o  = pins_q.cs;
  assign ck_o  = pins_q.ck;
  assign dat_o = pins_q.dat;

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> ($stable(idx_fr_q) && $stable(dat_fr_q))) else $error("words changed while busy"); // R9

endmodule

// File: rtl/pnl_reg_writer.sv
module pnl_reg_writer
  import pnl_wr_pkg::*;
#(
  parameter int            HALF_CYC = 200,
  parameter int            DW       = 8,
  parameter logic [DW-1:0] IDX_PFX  = 8'h70,
  parameter logic [DW-1:0] DAT_PFX  = 8'h72
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] val_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          cs_o,
  output logic          sclk_o,
  output logic          sdo_o
);
  localparam int FW      = 2 * DW;
  localparam int PPF     = 2 * FW;
  localparam int PH_LAST = 2 * PPF + 1;
  localparam int PH_W    = $clog2(PH_LAST + 1);

  sq_state_e       st;
  logic [PH_W-1:0] ph;
  logic            tick;
  logic            load;

  pnl_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (st == SQ_RUN),
    .tick_o (tick)
  );

  pnl_phase_seq #(.PH_LAST(PH_LAST), .PH_W(PH_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .tick_i  (tick),
    .st_o    (st),
    .ph_o    (ph),
    .load_o  (load),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  pnl_pin_decode #(.DW(DW), .IDX_PFX(IDX_PFX), .DAT_PFX(DAT_PFX), .PH_W(PH_W)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .idx_i  (idx_i),
    .val_i  (val_i),
    .busy_i (busy_o),
    .st_i   (st),
    .ph_i   (ph),
    .cs_o   (cs_o),
    .ck_o   (sclk_o),
    .dat_o  (sdo_o)
  );

  AST_REST_PINS: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (cs_o && !sclk_o && !sdo_o)) else $error("lines not at rest while idle"); // R1
  AST_SEL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    !cs_o |-> busy_o) else $error("select low while not busy"); // R8
  AST_FRAME_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_o) |-> ($past(sclk_o) && $past(sdo_o))) else $error("word not entered from all-high"); // R4
  AST_DONE_AT_REST: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cs_o && !sclk_o && !sdo_o && $past(cs_o) && !$past(sclk_o) && !$past(sdo_o)))
    else $error("done before lines rested"); // R7

endmodule

// File: tb/pnl_reg_writer_tb_top.sv
module pnl_reg_writer_tb_top;
  localparam int HALF = 3;
  localparam int DW   = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          start;
  logic [DW-1:0] idx;
  logic [DW-1:0] val;
  logic          busy, done, cs, sclk, sdo;

  pnl_reg_writer #(.HALF_CYC(HALF), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .idx_i(idx), .val_i(val),
    .busy_o(busy), .done_o(done), .cs_o(cs), .sclk_o(sclk), .sdo_o(sdo)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // line monitor
  logic        p_cs = 1'b1, p_ck = 1'b0;
  int          ck_run = 0, hi_run = 0, nfall = 0, nfr = 0, bad_len = 0;
  int          hi_runs [0:1];
  logic [15:0] frames  [0:3];
  logic [15:0] sh = '0;

  always @(negedge clk) begin
    if (rst) begin
      p_cs = 1'b1; p_ck = 1'b0; ck_run = 0; hi_run = 0;
    end else begin
      if (p_cs && !cs) begin
        if (nfall < 2) hi_runs[nfall] = hi_run;
        nfall++;
        sh = '0;
      end
      if (!p_cs && cs) begin
        if (nfr < 4) frames[nfr] = sh;
        nfr++;
      end
      if (sclk != p_ck) begin
        if (!p_cs && ck_run != HALF) bad_len++;
        if (sclk && !cs) sh = {sh[14:0], sdo};
        ck_run = 1;
      end else begin
        ck_run++;
      end
      if (cs && sclk && sdo) hi_run++; else hi_run = 0;
      p_cs = cs; p_ck = sclk;
    end
  end

  task automatic do_write(input logic [7:0] wi, input logic [7:0] wv, input bit inject, input bit chained);
    int   cyc;
    logic last_rest;
    nfr = 0; nfall = 0; bad_len = 0;
    hi_runs[0] = -1; hi_runs[1] = -1;
    start = 1'b1; idx = wi; val = wv;
    @(negedge clk);
    start = 1'b0; idx = ~wi; val = ~wv;
    if (chained) chk(busy == 1'b1, "R11 request in done cycle accepted", busy, 1);
    else         chk(busy == 1'b1, "R8 busy after accepted request", busy, 1);
    chk(done == 1'b0, "R10 done lasts one cycle", done, 0);
    cyc = 0;
    last_rest = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (done) break;
      if (inject && cyc == 40) begin
        chk(busy == 1'b1, "R8 busy mid write", busy, 1);
        start = 1'b1; idx = wi ^ 8'h3c; val = wv ^ 8'hc3;
      end else begin
        start = 1'b0;
      end
      last_rest = cs && !sclk && !sdo;
    end
    chk(frames[0] == {8'h70, wi}, inject ? "R9 index word kept" : "R2 index word", frames[0], {8'h70, wi});
    chk(frames[1] == {8'h72, wv}, inject ? "R9 value word kept" : "R3 value word", frames[1], {8'h72, wv});
    chk(nfr == 2, "R2 two words per write", nfr, 2);
    chk(hi_runs[0] == HALF, "R4 lead-in high length", hi_runs[0], HALF);
    chk(hi_runs[1] == HALF, "R6 gap high length", hi_runs[1], HALF);
    chk(bad_len == 0, "R5 clock phase lengths", bad_len, 0);
    chk(cs && !sclk && !sdo, "R7 lines at end", {cs, sclk, sdo}, 3'b100);
    chk(last_rest && !busy, "R10 done after rest, busy low", {last_rest, busy}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0; idx = '0; val = '0;
    repeat (3) @(negedge clk);
    chk({cs, sclk, sdo, busy, done} == 5'b10000, "R1 state in reset", {cs, sclk, sdo, busy, done}, 5'b10000);
    rst = 1'b0;
    @(negedge clk);
    chk({cs, sclk, sdo, busy, done} == 5'b10000, "R1 state after reset", {cs, sclk, sdo, busy, done}, 5'b10000);

    do_write(8'h00, 8'h00, 1'b0, 1'b0);
    do_write(8'hff, 8'hff, 1'b0, 1'b1);
    do_write(8'ha5, 8'h5a, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    chk({cs, sclk, sdo, busy, done} == 5'b10000, "R1 rest between writes", {cs, sclk, sdo, busy, done}, 5'b10000);
    do_write(8'h01, 8'h80, 1'b0, 1'b0);

    for (int i = 0; i < 20; i++) begin
      logic [7:0] ri, rv;
      bit inj, gap;
      ri  = 8'($urandom);
      rv  = 8'($urandom);
      inj = ($urandom % 4) == 0;
      gap = ($urandom % 2) == 0;
      if (gap) repeat (1 + $urandom % 4) @(negedge clk);
      do_write(ri, rv, inj, !gap);
    end
    summary();
  end

endmodule